// File: doc/BRIEF.md
# Polled Four-Result Conversion Sequencer

This block is a bus-slave peripheral that runs a burst of four timed conversions and keeps their results in a small register window for a CPU to read. The analog converter is not modelled. Each of eight channels delivers a digital byte on its own input lane. Each conversion slot lasts a fixed number of clock cycles. At the last cycle of a slot, the sample of the channel that slot uses is latched into the result register for that slot.

Software starts a burst by writing the control/status register at offset 0. It then polls bit 7 of the same register until that bit reads 1, and reads the four result registers at offsets 1 to 4. Reading the control/status register returns status and writing it issues a command. The bit positions are the same in both directions, so software can read the register, OR in a bit and write it back. The written copy of the completion bit is ignored.

Two control bits change the behaviour. Group mode spreads the four conversions over four neighbouring channels. Repeat mode keeps the sequencer looping over the four slots and refreshing the results.

Top module: `sample_burst_sequencer`

## Requirements
- R1: The window is eight byte offsets.
  - Offset 0 is control/status and offsets 1 to 4 hold the results of conversions 1 to 4.
  - Offsets 5 to 7 read 0.
  - Read data appears on `bus_rdata` the cycle after `bus_re` is sampled high, and holds its value while `bus_re` is low.
- R2: Reading offset 0 returns these fields:
  - bit 7: completion flag.
  - bit 5: repeat mode.
  - bit 4: group mode.
  - bits 2:0: channel select.
  - Bits 6 and 3 read 0. Bits 5, 4 and 2:0 read back as last written.
- R3: A write to offset 0 clears the completion flag and restarts the sequence from conversion 1, even in the middle of a burst. Bit 7 of the written value has no effect.
- R4: The write edge counts as cycle 0. Conversion k (k = 1 to 4) latches the sample present just before edge 32·k. The completion flag reads 0 in the state after edge 127 and 1 in the state after edge 128.
- R5: With group mode off, all four conversions sample the channel given by bits 2:0.
- R6: With group mode on, conversion k samples channel {bit 2, k−1}, so bits 1:0 are ignored.
  - Channel c occupies bits 8c+7:8c of `chan_smp`.
- R7: With repeat mode off, the sequencer stops after conversion 4. The results then hold even when the inputs change, and the completion flag stays 1 until the next write to offset 0.
- R8: With repeat mode on, the sequencer restarts at once after conversion 4. Conversion k is captured again at edge 128+32·k, and so on. The completion flag stays 1 from the first full pass onward.
- R9: Writes to offsets 1 to 7 are ignored. They leave the results, the control fields, the completion flag and the sequence timing unchanged.
- R10: Reads never alter the results, the completion flag or the sequence timing.
- R11: After reset the control fields, the completion flag and all results are 0, and no sequence runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (3) | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| chan_smp | input | 64 | Eight 8-bit channel sample lanes, channel c at bits 8c+7:8c |

## Verification
Three results have fixed due cycles, all counted from the edge that samples the control write:
- A result appears one cycle after its read strobe.
- Conversion k latches its sample at edge 32·k.
- The completion flag turns 1 at edge 128.

The bench keeps a running count of edges since the last control write. Each read consumes one edge, so a read issued after edge m shows the state left by edge m. Channel inputs are changed on falling edges at chosen counts, so each slot captures a distinct value. The completion flag is checked at counts 127 and 128, one edge apart, to pin its exact cycle.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_CH   = 8;
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int NUM_RES  = 4;
    localparam int RES_W    = $clog2(NUM_RES);
    localparam int DONE_BIT = 7;
    localparam int REP_BIT  = 5;
    localparam int GRP_BIT  = 4;

    typedef struct packed {
        logic            rep;
        logic            grp;
        logic [CH_W-1:0] chan;
    } ctrl_t;
endpackage

// File: rtl/sbs_slot_timer.sv
module sbs_slot_timer #(
    parameter  int SLOT_CYCLES = 32,
    parameter  int NUM_SLOTS   = 4,
    localparam int CNT_W       = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1,
    localparam int IDX_W       = (NUM_SLOTS > 2) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             repeat_i,
    output logic [IDX_W-1:0] slot_o,
    output logic             slot_end_o,
    output logic             pass_end_o
);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(SLOT_CYCLES - 1);
    localparam logic [IDX_W-1:0] SLOT_LAST = IDX_W'(NUM_SLOTS - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] slot;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tq, td;

    always_comb begin
        td = tq;
        if (start_i) begin
            td.busy = 1'b1;
            td.slot = '0;
            td.cnt  = '0;
        end else if (tq.busy) begin
            if (tq.cnt == CNT_LAST) begin
                td.cnt = '0;
                if (tq.slot == SLOT_LAST) begin
                    td.slot = '0;
                    td.busy = repeat_i;
                end else begin
                    td.slot = tq.slot + IDX_W'(1);
                end
            end else begin
                td.cnt = tq.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tq <= '0;
        else        tq <= td;
    end

    assign slot_o     = tq.slot;
    assign slot_end_o = tq.busy && (tq.cnt == CNT_LAST);
    assign pass_end_o = slot_end_o && (tq.slot == SLOT_LAST);
endmodule

// File: rtl/sbs_chan_pick.sv
module sbs_chan_pick #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3,
    parameter int IDX_W  = 2,
    parameter int SMP_W  = 8
) (
    input  logic [NUM_CH*SMP_W-1:0] lanes_i,
    input  logic [CH_W-1:0]         chan_i,
    input  logic                    grp_i,
    input  logic [IDX_W-1:0]        slot_i,
    output logic [SMP_W-1:0]        smp_o
);
    logic [SMP_W-1:0] lane [NUM_CH];
    logic [CH_W-1:0]  sel;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        assign lane[c] = lanes_i[c*SMP_W +: SMP_W];
    end

    if (CH_W > IDX_W) begin : g_grp_hi
        assign sel = grp_i ? {chan_i[CH_W-1:IDX_W], slot_i} : chan_i;
    end else begin : g_grp_flat
        assign sel = grp_i ? CH_W'(slot_i) : chan_i;
    end

    assign smp_o = lane[sel];
endmodule

// File: rtl/sample_burst_sequencer.sv
module sample_burst_sequencer
    import sbs_pkg::*;
#(
    parameter int SLOT_CYCLES = 32,
    parameter int ADDR_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [REG_W-1:0]        bus_wdata,
    input  logic                    bus_we,
    input  logic                    bus_re,
    output logic [REG_W-1:0]        bus_rdata,
    input  logic [NUM_CH*REG_W-1:0] chan_smp
);
    typedef struct packed {
        ctrl_t                         ctrl;
        logic                          done;
        logic [NUM_RES-1:0][REG_W-1:0] res;
        logic [REG_W-1:0]              rdata;
    } state_t;

    state_t st_q, st_d;

    logic             start;
    logic [RES_W-1:0] slot;
    logic             slot_end;
    logic             pass_end;
    logic [REG_W-1:0] smp;
    logic [REG_W-1:0] rd_mux;
    logic             done_q;
    logic             unused_wbits;

    assign start        = bus_we && (bus_addr == ADDR_W'(0));
    assign unused_wbits = ^{bus_wdata[DONE_BIT], bus_wdata[6], bus_wdata[3]};

    sbs_slot_timer #(
        .SLOT_CYCLES (SLOT_CYCLES),
        .NUM_SLOTS   (NUM_RES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .repeat_i   (st_q.ctrl.rep),
        .slot_o     (slot),
        .slot_end_o (slot_end),
        .pass_end_o (pass_end)
    );

    sbs_chan_pick #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .IDX_W  (RES_W),
        .SMP_W  (REG_W)
    ) u_pick (
        .lanes_i (chan_smp),
        .chan_i  (st_q.ctrl.chan),
        .grp_i   (st_q.ctrl.grp),
        .slot_i  (slot),
        .smp_o   (smp)
    );

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(0)) begin
            rd_mux[DONE_BIT]   = st_q.done;
            rd_mux[REP_BIT]    = st_q.ctrl.rep;
            rd_mux[GRP_BIT]    = st_q.ctrl.grp;
            rd_mux[CH_W-1:0]   = st_q.ctrl.chan;
        end else if (bus_addr <= ADDR_W'(NUM_RES)) begin
            rd_mux = st_q.res[RES_W'(bus_addr - ADDR_W'(1))];
        end
    end

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.ctrl.rep  = bus_wdata[REP_BIT];
            st_d.ctrl.grp  = bus_wdata[GRP_BIT];
            st_d.ctrl.chan = bus_wdata[CH_W-1:0];
            st_d.done      = 1'b0;
        end else if (slot_end) begin
            st_d.res[slot] = smp;
            if (pass_end) st_d.done = 1'b1;
        end
        if (bus_re) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign done_q    = st_q.done;
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter  int SLOT_CYCLES = 32,
    parameter  int NUM_SLOTS   = 4,
    parameter  int ADDR_W      = 3,
    localparam int PASS_LEN    = SLOT_CYCLES * NUM_SLOTS,
    localparam int AGE_W       = $clog2(PASS_LEN + 2) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [7:0]        bus_rdata,
    input logic              done_flag
);
    logic             ctl_wr;
    logic [AGE_W-1:0] age_q;

    assign ctl_wr = bus_we && (bus_addr == ADDR_W'(0));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          age_q <= '0;
        else if (ctl_wr)                     age_q <= '0;
        else if (age_q != {AGE_W{1'b1}})     age_q <= age_q + AGE_W'(1);
    end

    // R3: a control write clears the completion flag
    a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> !done_flag);

    // R4: completion flag rises exactly one full pass after the control write
    a_r4_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> (age_q == AGE_W'(PASS_LEN)));

    // R7: completion flag is sticky until the next control write
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !ctl_wr) |=> done_flag);

    // R1: read data holds while no read strobe is given
    a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));
endmodule

bind sample_burst_sequencer sbs_checker #(
    .SLOT_CYCLES (SLOT_CYCLES),
    .NUM_SLOTS   (sbs_pkg::NUM_RES),
    .ADDR_W      (ADDR_W)
) u_sbs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .done_flag (done_q)
);

// File: tb/sample_burst_sequencer_bench.sv
module sample_burst_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic [63:0] chan_smp = '0;

    int checks = 0;
    int errors = 0;
    int m = 0;
    logic [7:0] rv;
    logic [7:0] keep;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sample_burst_sequencer u_sample_burst_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .chan_smp  (chan_smp)
    );

    // ctrl, expected result 1..4 ; lane c holds 8'hA0 + c
    localparam logic [39:0] VEC [6] = '{
        {8'h02, 8'hA2, 8'hA2, 8'hA2, 8'hA2},
        {8'h05, 8'hA5, 8'hA5, 8'hA5, 8'hA5},
        {8'h10, 8'hA0, 8'hA1, 8'hA2, 8'hA3},
        {8'h14, 8'hA4, 8'hA5, 8'hA6, 8'hA7},
        {8'h17, 8'hA4, 8'hA5, 8'hA6, 8'hA7},
        {8'h90, 8'hA0, 8'hA1, 8'hA2, 8'hA3}
    };

    task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic set_ch(input int c, input logic [7:0] v);
        chan_smp[c*8 +: 8] = v;
    endtask

    task automatic advance(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        m += n;
    endtask

    task automatic advance_to(input int t);
        if (t > m) advance(t - m);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        if (a == 3'd0) m = 0; else m += 1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
        m += 1;
    endtask

    function automatic logic [7:0] stat(input logic done, input logic [7:0] c);
        return {done, 1'b0, c[5], c[4], 1'b0, c[2:0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 8; c++) set_ch(c, 8'hA0 + 8'(c));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        rd(3'd0, rv); check8("R11 ctrl after reset", rv, 8'h00);
        for (int k = 1; k <= 4; k++) begin
            rd(3'(k), rv); check8("R11 result after reset", rv, 8'h00);
        end
        // R1: unused offsets read 0
        for (int k = 5; k <= 7; k++) begin
            rd(3'(k), rv); check8("R1 unused offset", rv, 8'h00);
        end

        // Vector table: R2, R3 (bit 7 ignored), R4, R5, R6
        for (int i = 0; i < 6; i++) begin
            wr(3'd0, VEC[i][39:32]);
            advance_to(127);
            rd(3'd0, rv); check8("R4 flag low at 127", rv, stat(1'b0, VEC[i][39:32]));
            rd(3'd0, rv); check8("R2 R4 status at 128", rv, stat(1'b1, VEC[i][39:32]));
            rd(3'd1, rv); check8("R5 R6 result1", rv, VEC[i][31:24]);
            rd(3'd2, rv); check8("R5 R6 result2", rv, VEC[i][23:16]);
            rd(3'd3, rv); check8("R5 R6 result3", rv, VEC[i][15:8]);
            rd(3'd4, rv); check8("R5 R6 result4", rv, VEC[i][7:0]);
        end

        // R1: read data holds without a read strobe
        keep = bus_rdata;
        advance(5);
        check8("R1 rdata hold", bus_rdata, keep);

        // R7: single-shot results hold after inputs change
        for (int c = 0; c < 8; c++) set_ch(c, 8'h5A);
        advance(200);
        rd(3'd4, rv); check8("R7 result4 held", rv, 8'hA3);
        rd(3'd0, rv); check8("R7 flag still set", rv, 8'h90);

        // R4, R10: capture edge per slot, with a read mid-sequence
        set_ch(2, 8'h11);
        wr(3'd0, 8'h02);
        advance_to(31); set_ch(2, 8'h22);
        advance_to(63); set_ch(2, 8'h33);
        rd(3'd1, rv); check8("R10 read during burst", rv, 8'h22);
        advance_to(95); set_ch(2, 8'h44);
        advance_to(127); set_ch(2, 8'h55);
        rd(3'd0, rv); check8("R4 R10 flag low at 127", rv, 8'h02);
        rd(3'd0, rv); check8("R4 flag at 128", rv, 8'h82);
        rd(3'd1, rv); check8("R4 slot1 edge", rv, 8'h22);
        rd(3'd2, rv); check8("R4 slot2 edge", rv, 8'h33);
        rd(3'd3, rv); check8("R4 slot3 edge", rv, 8'h44);
        rd(3'd4, rv); check8("R4 slot4 edge", rv, 8'h55);

        // R9: writes to result offsets ignored, idle and mid-burst
        wr(3'd2, 8'hFF);
        wr(3'd6, 8'hFF);
        rd(3'd2, rv); check8("R9 result2 unchanged", rv, 8'h33);
        rd(3'd0, rv); check8("R9 ctrl unchanged", rv, 8'h82);
        set_ch(3, 8'h77);
        wr(3'd0, 8'h03);
        advance_to(50);
        wr(3'd3, 8'h00);
        wr(3'd1, 8'hEE);
        advance_to(127);
        rd(3'd0, rv); check8("R9 timing kept at 127", rv, 8'h03);
        rd(3'd0, rv); check8("R9 timing kept at 128", rv, 8'h83);
        rd(3'd1, rv); check8("R9 result1 not overwritten", rv, 8'h77);

        // R3: restart mid-burst
        set_ch(1, 8'h61);
        wr(3'd0, 8'h01);
        advance_to(60);
        set_ch(4, 8'h64);
        wr(3'd0, 8'h04);
        advance_to(127);
        rd(3'd0, rv); check8("R3 restart flag low", rv, 8'h04);
        rd(3'd0, rv); check8("R3 restart flag high", rv, 8'h84);
        rd(3'd1, rv); check8("R3 restart from conv1", rv, 8'h64);

        // R8: repeat mode refreshes results, flag stays set
        set_ch(1, 8'h31);
        wr(3'd0, 8'h21);
        advance_to(128);
        rd(3'd0, rv); check8("R8 flag first pass", rv, 8'hA1);
        advance_to(140);
        set_ch(1, 8'h41);
        advance_to(165);
        rd(3'd1, rv); check8("R8 result1 refreshed", rv, 8'h41);
        rd(3'd2, rv); check8("R8 result2 old pass", rv, 8'h31);
        advance_to(260);
        rd(3'd0, rv); check8("R8 flag stays set", rv, 8'hA1);
        rd(3'd4, rv); check8("R8 result4 refreshed", rv, 8'h41);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule